// File: doc/BRIEF.md
# Register-List Stack Save/Restore Sequencer

This block carries out the compressed stack save and restore instructions of a small RISC-V core. It accepts one 16-bit instruction together with the current stack pointer. It expands the instruction's 4-bit register-list field into a set of saved registers that is not contiguous, and works through that set one memory word per access. Stores read their data through a register-file read port. Loads write through a register-file write port. The stack-pointer write, and an optional return jump and zeroing of a0, happen at fixed points of the sequence.

The core pulses `start` while the sequencer is idle. `busy` then holds off further issue until the single `done` cycle. An access error or a misaligned stack pointer ends the sequence early with `fault`. An encoding that is not one of the four supported forms, or that carries a reserved list value, ends the sequence at once with `illegal` and makes no memory access. The word width is set by the `XLEN` parameter (32 or 64).

Top module: `regstack_seq`

## Requirements
- R1: An instruction is accepted only when bits [15:13]=101, bits [1:0]=10 and bits [12:8] are one of 11000 (save), 11010 (restore), 11110 (restore and return) or 11100 (restore, return and clear a0). Any other instruction finishes with `illegal` high in its `done` cycle. It makes no memory request and no register, sp or pc write.
- R2: A register-list value (bits [7:4]) of 0 to 3 is reserved and behaves like R1's illegal case.
- R3: List value 4 selects x1 alone. Value 5 adds x8 and value 6 adds x9. Each value from 7 to 14 adds the next register from x18 upward. Value 15 selects x1, x8, x9 and x18 to x27. The selected registers are accessed from the highest index down to x1.
- R4: The first access address is the base minus one word (XLEN/8 bytes), and each following access is one word lower. The base is the old sp for a save and the new sp for a restore.
- R5: With XLEN=32 the stack adjustment is 16 for list values 4–7, 32 for 8–11, 48 for 12–14 and 64 for 15. To this is added 16 times the immediate in bits [3:2].
- R6: A save stores each selected register's value. It writes sp = old sp − adjustment in its `done` cycle, only after the last store succeeded, and writes no register or pc.
- R7: A restore writes sp = old sp + adjustment before its first memory request. Each loaded word is written to its register.
- R8: Restore-and-return writes the loaded x1 value to the pc in the `done` cycle. The clearing variant also writes zero to x10. A plain restore writes no pc and leaves x10 alone.
- R9: An error response ends the sequence. No further request is made, and `done` and `fault` are raised in the next cycle. A failed save leaves sp unchanged.
- R10: If the low address bits of the stack pointer are not zero, the sequence ends with `fault` and no memory request.
- R11: `busy` is high from the cycle after an accepted `start` through the `done` cycle. `start` is ignored while busy, and each accepted `start` yields exactly one `done`.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| start | input | 1 | Issue pulse, taken when idle |
| instr | input | 16 | Compressed instruction |
| sp_in | input | XLEN | Current stack pointer |
| rf_raddr | output | 5 | Register-file read index |
| rf_rdata | input | XLEN | Register-file read data (combinational) |
| rf_we | output | 1 | Register-file write enable |
| rf_waddr | output | 5 | Register-file write index |
| rf_wdata | output | XLEN | Register-file write data |
| sp_we | output | 1 | Stack-pointer write enable |
| sp_wdata | output | XLEN | New stack pointer |
| pc_we | output | 1 | Next-pc redirect enable |
| pc_wdata | output | XLEN | Redirect target |
| mem_req | output | 1 | Memory request, held until acknowledged |
| mem_we | output | 1 | Request is a store |
| mem_addr | output | XLEN | Byte address |
| mem_wdata | output | XLEN | Store data |
| mem_ack | input | 1 | Response for the current request |
| mem_err | input | 1 | Response is an error |
| mem_rdata | input | XLEN | Load data, valid with mem_ack |
| busy | output | 1 | Sequence in progress |
| done | output | 1 | Final cycle of a sequence |
| fault | output | 1 | Sequence ended by an access problem |
| illegal | output | 1 | Instruction rejected |

## Verification
Every list value from 4 to 15 is run with every immediate for all four operations. This sweep separates the list decoding (access count and register order), the adjustment table (final sp) and the differences between the operations (pc and x10 writes, and where the sp write falls). Reserved list values and corrupted opcode fields show that rejection makes no accesses. An error on the third store of a save, an error during a restore, and a misaligned stack pointer show the abort paths. A second `start` during a sequence shows that a new issue is blocked while busy.

// File: rtl/regstack_seq.sv
module regstack_seq #(
  parameter int XLEN = 32
) (
  input  logic            clk,
  input  logic            rst_n,
  input  logic            start,
  input  logic [15:0]     instr,
  input  logic [XLEN-1:0] sp_in,
  output logic [4:0]      rf_raddr,
  input  logic [XLEN-1:0] rf_rdata,
  output logic            rf_we,
  output logic [4:0]      rf_waddr,
  output logic [XLEN-1:0] rf_wdata,
  output logic            sp_we,
  output logic [XLEN-1:0] sp_wdata,
  output logic            pc_we,
  output logic [XLEN-1:0] pc_wdata,
  output logic            mem_req,
  output logic            mem_we,
  output logic [XLEN-1:0] mem_addr,
  output logic [XLEN-1:0] mem_wdata,
  input  logic            mem_ack,
  input  logic            mem_err,
  input  logic [XLEN-1:0] mem_rdata,
  output logic            busy,
  output logic            done,
  output logic            fault,
  output logic            illegal
);
  localparam int W  = XLEN / 8;
  localparam int AW = $clog2(W);

  typedef enum logic [1:0] {S_IDLE, S_ADJ, S_REQ, S_END} st_t;

  function automatic logic [XLEN-1:0] stack_adj(input logic [3:0] rl, input logic [1:0] im);
    logic [7:0] b;
    if (XLEN == 32) b = (rl == 4'hf) ? 8'd64 : {2'b00, rl[3:2], 4'b0000};
    else            b = (rl == 4'hf) ? 8'd112 : ({1'b0, rl[3:1], 4'b0000} - 8'd16);
    return XLEN'(b) + XLEN'({im, 4'b0000});
  endfunction

  function automatic logic [4:0] regsel(input logic [3:0] k);
    case (k)
      4'd0:    return 5'd1;
      4'd1:    return 5'd8;
      4'd2:    return 5'd9;
      default: return {1'b0, k} + 5'd15;
    endcase
  endfunction

  st_t st;
  logic is_push, ret, zero, failed, bad;
  logic [3:0] k;
  logic [XLEN-1:0] addr, sp_new, ra_q;

  wire [3:0] rl      = instr[7:4];
  wire [1:0] im      = instr[3:2];
  wire [4:0] opf     = instr[12:8];
  wire       fmt_ok  = (instr[15:13] == 3'b101) && (instr[1:0] == 2'b10);
  wire       op_push = opf == 5'b11000;
  wire       op_pop  = opf == 5'b11010;
  wire       op_rz   = opf == 5'b11100;
  wire       op_r    = opf == 5'b11110;
  wire       valid   = fmt_ok && (op_push || op_pop || op_rz || op_r) && (rl >= 4'd4);
  wire [XLEN-1:0] adj = stack_adj(rl, im);
  wire       misal   = |addr[AW-1:0];
  wire       step_ok = (st == S_REQ) && !misal && mem_ack && !mem_err;

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      st <= S_IDLE; is_push <= 1'b0; ret <= 1'b0; zero <= 1'b0;
      failed <= 1'b0; bad <= 1'b0; k <= '0;
      addr <= '0; sp_new <= '0; ra_q <= '0;
    end else begin
      case (st)
        S_IDLE: if (start) begin
          is_push <= op_push && valid;
          ret     <= (op_r || op_rz) && valid;
          zero    <= op_rz && valid;
          failed  <= 1'b0;
          bad     <= !valid;
          k       <= (rl == 4'hf) ? 4'd12 : rl - 4'd4;
          if (!valid) st <= S_END;
          else if (op_push) begin
            st <= S_REQ; addr <= sp_in - XLEN'(W); sp_new <= sp_in - adj;
          end else begin
            st <= S_ADJ; addr <= sp_in + adj - XLEN'(W); sp_new <= sp_in + adj;
          end
        end
        S_ADJ: st <= S_REQ;
        S_REQ: begin
          if (misal) begin
            failed <= 1'b1; st <= S_END;
          end else if (mem_ack) begin
            if (mem_err) begin
              failed <= 1'b1; st <= S_END;
            end else if (k == 4'd0) begin
              st <= S_END; ra_q <= mem_rdata;
            end else begin
              k <= k - 4'd1; addr <= addr - XLEN'(W);
            end
          end
        end
        default: st <= S_IDLE;
      endcase
    end
  end

  assign busy      = st != S_IDLE;
  assign done      = st == S_END;
  assign fault     = done && failed;
  assign illegal   = done && bad;
  assign rf_raddr  = regsel(k);
  assign mem_req   = (st == S_REQ) && !misal;
  assign mem_we    = is_push;
  assign mem_addr  = addr;
  assign mem_wdata = rf_rdata;
  assign rf_we     = (step_ok && !is_push) || (done && zero && !failed);
  assign rf_waddr  = done ? 5'd10 : regsel(k);
  assign rf_wdata  = done ? '0 : mem_rdata;
  assign sp_we     = (st == S_ADJ) || (done && is_push && !failed);
  assign sp_wdata  = sp_new;
  assign pc_we     = done && ret && !failed;
  assign pc_wdata  = ra_q;
endmodule

// File: rtl/regstack_seq_chk.sv
module regstack_seq_chk #(
  parameter int XLEN = 32
) (
  input logic            clk,
  input logic            rst_n,
  input logic            mem_req,
  input logic            mem_we,
  input logic            mem_ack,
  input logic            mem_err,
  input logic [XLEN-1:0] mem_addr,
  input logic            sp_we,
  input logic            pc_we,
  input logic            busy,
  input logic            done,
  input logic            fault,
  input logic            illegal
);
  localparam int W = XLEN / 8;

  p_down_step_r4: assert property (@(posedge clk) disable iff (!rst_n)
    (mem_req && $past(mem_req && mem_ack && !mem_err)) |-> mem_addr == $past(mem_addr) - XLEN'(W));

  p_err_stop_r9: assert property (@(posedge clk) disable iff (!rst_n)
    (mem_req && mem_ack && mem_err) |=> (done && fault && !mem_req));

  p_busy_end_r11: assert property (@(posedge clk) disable iff (!rst_n)
    $fell(busy) |-> $past(done));

  p_store_no_sp_r6: assert property (@(posedge clk) disable iff (!rst_n)
    (mem_req && mem_we) |-> !sp_we);

  p_pc_at_end_r8: assert property (@(posedge clk) disable iff (!rst_n)
    pc_we |-> (done && !mem_req && !fault));

  p_illegal_quiet_r2: assert property (@(posedge clk) disable iff (!rst_n)
    illegal |-> (!fault && !sp_we && !pc_we && $past(!mem_req)));
endmodule

bind regstack_seq regstack_seq_chk #(.XLEN(XLEN)) chk_i (
  .clk(clk), .rst_n(rst_n), .mem_req(mem_req), .mem_we(mem_we), .mem_ack(mem_ack),
  .mem_err(mem_err), .mem_addr(mem_addr), .sp_we(sp_we), .pc_we(pc_we),
  .busy(busy), .done(done), .fault(fault), .illegal(illegal));

// File: tb/regstack_seq_tb_top.sv
module regstack_seq_tb_top;
  localparam int CLK_NS = 10;
  localparam int XLEN = 32;

  logic clk = 1'b0;
  logic rst_n = 1'b0;
  always #(CLK_NS/2) clk = ~clk;

  logic start = 1'b0;
  logic [15:0] instr = '0;
  logic [31:0] sp_cur;
  logic [4:0] rf_raddr, rf_waddr;
  logic [31:0] rf_rdata, rf_wdata, sp_wdata, pc_wdata, mem_addr, mem_wdata;
  logic rf_we, sp_we, pc_we, mem_req, mem_we, busy, done, fault, illegal;
  logic mem_ack = 1'b0, mem_err = 1'b0;
  logic [31:0] mem_rdata = '0;

  logic [31:0] rf [32];
  logic prep = 1'b0;
  logic [31:0] sp_load = 32'h2000;
  logic [31:0] err_addr = 32'hFFFF_FFFF;
  logic [31:0] log_addr [16];
  logic [31:0] log_data [16];
  logic        log_we [16];
  int n_log, n_done, n_spwe, n_rfwe, n_pcwe;
  logic last_fault, last_ill, req_sp_ok, seen_req;
  logic [31:0] pc_val;
  int vec = 0, bad = 0;

  regstack_seq #(.XLEN(XLEN)) dut_i (
    .clk(clk), .rst_n(rst_n), .start(start), .instr(instr), .sp_in(sp_cur),
    .rf_raddr(rf_raddr), .rf_rdata(rf_rdata), .rf_we(rf_we), .rf_waddr(rf_waddr),
    .rf_wdata(rf_wdata), .sp_we(sp_we), .sp_wdata(sp_wdata), .pc_we(pc_we),
    .pc_wdata(pc_wdata), .mem_req(mem_req), .mem_we(mem_we), .mem_addr(mem_addr),
    .mem_wdata(mem_wdata), .mem_ack(mem_ack), .mem_err(mem_err), .mem_rdata(mem_rdata),
    .busy(busy), .done(done), .fault(fault), .illegal(illegal));

  function automatic logic [31:0] rf_init(int i);
    return 32'hA500_0000 | (32'(i) << 16) | (32'(i) * 32'd37);
  endfunction

  function automatic logic [31:0] mem_pat(logic [31:0] a);
    return 32'h6B00_0000 ^ (a * 32'd3);
  endfunction

  function automatic bit sel(logic [3:0] rl, int r);
    if (rl < 4) return 1'b0;
    if (r == 1) return 1'b1;
    if (r == 8) return rl >= 5;
    if (r == 9) return rl >= 6;
    if (r >= 18 && r <= 27) return (rl == 15) || (r < 12 + int'(rl));
    return 1'b0;
  endfunction

  function automatic logic [31:0] exp_adj(logic [3:0] rl, logic [1:0] im);
    int b;
    b = (rl < 8) ? 16 : (rl < 12) ? 32 : (rl < 15) ? 48 : 64;
    return 32'(b + 16 * int'(im));
  endfunction

  assign rf_rdata = rf[rf_raddr];

  always @(posedge clk) begin
    if (prep) begin
      for (int i = 0; i < 32; i++) rf[i] <= (i == 0) ? 32'h0 : rf_init(i);
      sp_cur <= sp_load;
      n_log <= 0; n_done <= 0; n_spwe <= 0; n_rfwe <= 0; n_pcwe <= 0;
      last_fault <= 1'b0; last_ill <= 1'b0; req_sp_ok <= 1'b0; seen_req <= 1'b0; pc_val <= '0;
    end else begin
      if (rf_we && rf_waddr != 5'd0) rf[rf_waddr] <= rf_wdata;
      if (rf_we) n_rfwe <= n_rfwe + 1;
      if (sp_we) begin sp_cur <= sp_wdata; n_spwe <= n_spwe + 1; end
      if (pc_we) begin pc_val <= pc_wdata; n_pcwe <= n_pcwe + 1; end
      if (done) begin n_done <= n_done + 1; last_fault <= fault; last_ill <= illegal; end
      if (mem_req && !seen_req) begin seen_req <= 1'b1; req_sp_ok <= (n_spwe > 0); end
      if (mem_req && mem_ack && n_log < 16) begin
        log_addr[n_log] <= mem_addr; log_data[n_log] <= mem_wdata; log_we[n_log] <= mem_we;
        n_log <= n_log + 1;
      end
    end
    mem_ack   <= mem_req && !mem_ack;
    mem_err   <= mem_req && !mem_ack && (mem_addr == err_addr);
    mem_rdata <= mem_pat(mem_addr);
  end

  task automatic chk(bit ok, string req, string what, logic [31:0] act, logic [31:0] exp);
    vec++;
    if (!ok) begin
      bad++;
      $display("FAIL %s %s: actual %h expected %h", req, what, act, exp);
    end
  endtask

  task automatic do_prep(logic [31:0] sp0);
    @(negedge clk); sp_load = sp0; prep = 1'b1;
    @(negedge clk); prep = 1'b0;
  endtask

  task automatic issue(logic [15:0] ins);
    @(negedge clk); instr = ins; start = 1'b1;
    @(negedge clk); start = 1'b0;
  endtask

  task automatic wait_done();
    int t = 0;
    while (!done && t < 400) begin @(negedge clk); t++; end
    chk(done, "R11", "done seen", 32'(done), 32'd1);
    @(negedge clk);
    @(negedge clk);
  endtask

  function automatic logic [15:0] mk(logic [4:0] op, logic [3:0] rl, logic [1:0] im);
    return {3'b101, op, rl, im, 2'b10};
  endfunction

  task automatic t_push(logic [3:0] rl, logic [1:0] im);
    logic [31:0] sp0 = 32'h2000;
    int regs[13];
    int n = 0;
    for (int r = 31; r >= 1; r--) if (sel(rl, r)) begin regs[n] = r; n++; end
    do_prep(sp0);
    issue(mk(5'b11000, rl, im));
    wait_done();
    chk(n_log == n, "R3", "save access count", 32'(n_log), 32'(n));
    for (int j = 0; j < n && j < n_log; j++) begin
      chk(log_addr[j] == sp0 - 32'(4 * (j + 1)), "R4", "save address", log_addr[j], sp0 - 32'(4 * (j + 1)));
      chk(log_we[j] && log_data[j] == rf_init(regs[j]), "R3", "save data/order", log_data[j], rf_init(regs[j]));
    end
    chk(sp_cur == sp0 - exp_adj(rl, im), "R5", "sp after save", sp_cur, sp0 - exp_adj(rl, im));
    chk(n_rfwe == 0 && n_pcwe == 0 && !last_fault, "R6", "save side writes", 32'(n_rfwe + n_pcwe), 32'd0);
  endtask

  task automatic t_pop(logic [4:0] op, logic [3:0] rl, logic [1:0] im);
    logic [31:0] sp0 = 32'h2000;
    logic [31:0] nsp;
    int regs[13];
    int n = 0;
    for (int r = 31; r >= 1; r--) if (sel(rl, r)) begin regs[n] = r; n++; end
    nsp = sp0 + exp_adj(rl, im);
    do_prep(sp0);
    issue(mk(op, rl, im));
    wait_done();
    chk(n_log == n, "R3", "restore access count", 32'(n_log), 32'(n));
    chk(req_sp_ok, "R7", "sp written before first load", 32'(req_sp_ok), 32'd1);
    chk(sp_cur == nsp, "R5", "sp after restore", sp_cur, nsp);
    for (int j = 0; j < n && j < n_log; j++) begin
      chk(!log_we[j] && log_addr[j] == nsp - 32'(4 * (j + 1)), "R4", "restore address", log_addr[j], nsp - 32'(4 * (j + 1)));
      if (regs[j] != 10)
        chk(rf[regs[j]] == mem_pat(nsp - 32'(4 * (j + 1))), "R7", "loaded register", rf[regs[j]], mem_pat(nsp - 32'(4 * (j + 1))));
    end
    if (op == 5'b11010) begin
      chk(n_pcwe == 0, "R8", "plain restore pc writes", 32'(n_pcwe), 32'd0);
      chk(rf[10] == rf_init(10), "R8", "plain restore x10", rf[10], rf_init(10));
    end else begin
      chk(n_pcwe == 1 && pc_val == mem_pat(nsp - 32'(4 * n)), "R8", "return target", pc_val, mem_pat(nsp - 32'(4 * n)));
      if (op == 5'b11100) chk(rf[10] == 32'h0, "R8", "x10 cleared", rf[10], 32'h0);
      else                chk(rf[10] == rf_init(10), "R8", "x10 kept", rf[10], rf_init(10));
    end
    chk(!last_fault && !last_ill, "R7", "restore status", {30'd0, last_fault, last_ill}, 32'd0);
  endtask

  task automatic t_illegal(logic [15:0] ins, string req);
    do_prep(32'h2000);
    issue(ins);
    wait_done();
    chk(last_ill && !seen_req, req, "rejected without access", {30'd0, last_ill, seen_req}, 32'd2);
    chk(n_spwe == 0 && n_rfwe == 0 && n_pcwe == 0, req, "no writes after reject", 32'(n_spwe + n_rfwe + n_pcwe), 32'd0);
  endtask

  task automatic t_err_save();
    do_prep(32'h2000);
    err_addr = 32'h2000 - 32'd12;
    issue(mk(5'b11000, 4'd8, 2'd1));
    wait_done();
    err_addr = 32'hFFFF_FFFF;
    chk(n_log == 3, "R9", "accesses before abort", 32'(n_log), 32'd3);
    chk(last_fault, "R9", "fault flagged", 32'(last_fault), 32'd1);
    chk(sp_cur == 32'h2000 && n_spwe == 0, "R9", "sp kept on failed save", sp_cur, 32'h2000);
  endtask

  task automatic t_err_restore();
    logic [31:0] nsp = 32'h2000 + 32'd32;
    do_prep(32'h2000);
    err_addr = nsp - 32'd8;
    issue(mk(5'b11110, 4'd10, 2'd0));
    wait_done();
    err_addr = 32'hFFFF_FFFF;
    chk(n_log == 2 && last_fault, "R9", "restore abort", 32'(n_log), 32'd2);
    chk(n_pcwe == 0 && sp_cur == nsp, "R9", "no return after abort", 32'(n_pcwe), 32'd0);
  endtask

  task automatic t_misaligned();
    do_prep(32'h2002);
    issue(mk(5'b11000, 4'd6, 2'd0));
    wait_done();
    chk(last_fault && !seen_req, "R10", "misaligned sp", {30'd0, last_fault, seen_req}, 32'd2);
    chk(sp_cur == 32'h2002 && n_spwe == 0, "R10", "sp kept", sp_cur, 32'h2002);
  endtask

  task automatic t_busy_block();
    do_prep(32'h2000);
    issue(mk(5'b11000, 4'd6, 2'd0));
    @(negedge clk);
    chk(busy, "R11", "busy during sequence", 32'(busy), 32'd1);
    instr = mk(5'b11010, 4'd15, 2'd3); start = 1'b1;
    @(negedge clk); start = 1'b0;
    wait_done();
    repeat (6) @(negedge clk);
    chk(n_done == 1 && !busy, "R11", "one done per issue", 32'(n_done), 32'd1);
    chk(n_log == 3 && log_we[0] && log_we[2], "R11", "second issue ignored", 32'(n_log), 32'd3);
    chk(sp_cur == 32'h2000 - 32'd16, "R11", "sp from first issue only", sp_cur, 32'h2000 - 32'd16);
  endtask

  initial begin
    #(CLK_NS * 190000);
    bad++;
    $display("FAIL R11 watchdog: actual %h expected %h", 32'd0, 32'd1);
    $display("== %0d vectors applied, %0d miscompares ==", vec, bad);
    $finish;
  end

  initial begin
    sp_cur = 32'h2000;
    for (int i = 0; i < 32; i++) rf[i] = '0;
    repeat (3) @(negedge clk);
    chk(!busy && !done && !mem_req, "R11", "reset state", {29'd0, busy, done, mem_req}, 32'd0);
    rst_n = 1'b1;
    for (int rl = 4; rl < 16; rl++)
      for (int im = 0; im < 4; im++) begin
        t_push(4'(rl), 2'(im));
        t_pop(5'b11010, 4'(rl), 2'(im));
        t_pop(5'b11110, 4'(rl), 2'(im));
        t_pop(5'b11100, 4'(rl), 2'(im));
      end
    for (int rl = 0; rl < 4; rl++) t_illegal(mk(5'b11000, 4'(rl), 2'd0), "R2");
    t_illegal(mk(5'b11010, 4'd2, 2'd1), "R2");
    t_illegal(mk(5'b10000, 4'd8, 2'd0), "R1");
    t_illegal({3'b101, 5'b11000, 4'd8, 2'd0, 2'b01}, "R1");
    t_illegal({3'b100, 5'b11110, 4'd8, 2'd0, 2'b10}, "R1");
    t_err_save();
    t_err_restore();
    t_misaligned();
    t_busy_block();
    $display("== %0d vectors applied, %0d miscompares ==", vec, bad);
    $finish;
  end
endmodule